// File: doc/BRIEF.md
# Restart Region Exception Controller

This controller lets a vector unit retire results in any order inside software-delimited idempotent regions and still recover cleanly from a fault. The decoder reports region-open and region-close markers, each with the program counter of the marker. While a region is open, the only recovery state is one register holding the region's head address. Functional units retire work as soon as it is finished, and no results are buffered.

When any unit reports an exception, the controller raises a flush request with a restart address. Exceptions include a translation miss that is refilled by software. Inside a region, fetch is sent back to the region head, and the controller signals that only scalar architectural state must be saved, because vector registers are recreated when the region runs again. Outside a region, the controller falls back to precise recovery at the faulting instruction.

In counted-loop mode, units tag each completion with a loop-iteration index. The controller then also reports the oldest iteration that has not completed, so the handler can resume from that iteration and not from the first one. The flush outputs stay put until fetch acknowledges them.

Top module: `rrx_ctrl`

## Requirements
- R1: After reset, `flush_o`, `region_open_o`, `scalar_only_o` and `iter_valid_o` are 0, and `restart_pc_o` and `restart_iter_o` are 0.
- R2: A begin marker accepted at a clock edge opens the region from the next cycle. It stores `mark_pc_i` as the region head, latches `counted_i` as the mode, and clears the record of completed iterations.
- R3: An exception taken while a region is open raises `flush_o` in the next cycle, with `restart_pc_o` equal to the stored region head and `scalar_only_o` = 1.
- R4: An exception taken with no region open raises `flush_o` in the next cycle, with `restart_pc_o` equal to the faulting PC and `scalar_only_o` = 0. Unit f's PC is bits [f*PC_W +: PC_W] of `exc_pc_i`.
- R5: In counted mode, a completion from unit f marks the iteration given by `cmpl_iter_i[f*IT_W +: IT_W]` as done. Completions may arrive in any order and from several units in one cycle. On an exception, `restart_iter_o` is the lowest iteration index not yet done, with `iter_valid_o` = 1. If every iteration is done, both are 0.
- R6: On an exception in a region that is not in counted mode, and on any exception outside a region, `iter_valid_o` = 0 and `restart_iter_o` = 0.
- R7: Exceptions from several units in one cycle produce a single flush. Outside a region, the PC used is the one from the lowest-numbered reporting unit.
- R8: Completions that arrive in the same cycle as an accepted exception are dropped and do not count as done.
- R9: A begin marker while a region is open replaces the head and the mode and clears the completion record, as if the region had first been closed.
- R10: An end marker closes the region, so a later exception is handled precisely (R4).
- R11: While `flush_o` is 1, all flush outputs hold their values until a cycle with `flush_ack_i` = 1, after which `flush_o` is 0. Exceptions, markers and completions during that time are ignored.
- R12: When an exception and a marker are accepted in the same cycle, the exception is taken and the marker is dropped. A begin marker in the same cycle as an end marker wins over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mark_begin_i | input | 1 | Region-open marker event |
| mark_end_i | input | 1 | Region-close marker event |
| mark_pc_i | input | PC_W | PC of the marker |
| counted_i | input | 1 | Counted-loop mode for the region being opened |
| cmpl_vld_i | input | NUM_FU | Per-unit completion strobe |
| cmpl_iter_i | input | NUM_FU*IT_W | Per-unit iteration tag of the completion |
| exc_vld_i | input | NUM_FU | Per-unit exception strobe (includes software-refilled translation misses) |
| exc_pc_i | input | NUM_FU*PC_W | Per-unit faulting PC |
| flush_ack_i | input | 1 | Fetch has taken the redirect |
| flush_o | output | 1 | Flush and redirect request |
| restart_pc_o | output | PC_W | Address at which fetch resumes |
| restart_iter_o | output | IT_W | Oldest incomplete iteration |
| iter_valid_o | output | 1 | `restart_iter_o` is meaningful |
| scalar_only_o | output | 1 | Only scalar state needs saving |
| region_open_o | output | 1 | A restart region is open |

## Verification
The hardest situation to reach is a counted-loop fault whose answer depends on the completion record. In that case the iterations have retired out of order across different units, and a completion for the oldest gap arrives in the very cycle of the exception. The stimulus opens a counted region and retires iterations 3, 0 and 1 from separate units. It then sends the exception together with a completion for iteration 2, which must still be reported as the restart iteration. Later sequences fill every iteration before a fault, stack a second begin marker on an open region, and collide a marker with an exception. A behavioural model checks every cycle.

// File: rtl/rrx_pkg.sv
package rrx_pkg;
    localparam int unsigned RRX_PC_W   = 32;
    localparam int unsigned RRX_NUM_FU = 3;
    localparam int unsigned RRX_ITERS  = 8;
endpackage

// File: rtl/rrx_oldest_enc.sv
module rrx_oldest_enc #(
    parameter int unsigned N = 8,
    parameter int unsigned W = 3
) (
    input  logic [N-1:0] done_i,
    output logic [W-1:0] idx_o,
    output logic         found_o
);
    // Lowest clear bit wins: scan from the top so the last hit is the lowest.
    always_comb begin
        idx_o   = '0;
        found_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!done_i[i]) begin
                idx_o   = W'(i);
                found_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rrx_fault_pick.sv
module rrx_fault_pick #(
    parameter int unsigned N    = 3,
    parameter int unsigned PC_W = 32
) (
    input  logic [N-1:0]      vld_i,
    input  logic [N*PC_W-1:0] pcs_i,
    output logic              any_o,
    output logic [PC_W-1:0]   pc_o
);
    always_comb begin
        any_o = |vld_i;
        pc_o  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vld_i[i]) pc_o = pcs_i[i*PC_W +: PC_W];
        end
    end
endmodule

// File: rtl/rrx_ctrl.sv
module rrx_ctrl
    import rrx_pkg::*;
#(
    parameter int unsigned PC_W   = RRX_PC_W,
    parameter int unsigned NUM_FU = RRX_NUM_FU,
    parameter int unsigned ITERS  = RRX_ITERS,
    parameter int unsigned IT_W   = $clog2(ITERS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mark_begin_i,
    input  logic                   mark_end_i,
    input  logic [PC_W-1:0]        mark_pc_i,
    input  logic                   counted_i,
    input  logic [NUM_FU-1:0]      cmpl_vld_i,
    input  logic [NUM_FU*IT_W-1:0] cmpl_iter_i,
    input  logic [NUM_FU-1:0]      exc_vld_i,
    input  logic [NUM_FU*PC_W-1:0] exc_pc_i,
    input  logic                   flush_ack_i,
    output logic                   flush_o,
    output logic [PC_W-1:0]        restart_pc_o,
    output logic [IT_W-1:0]        restart_iter_o,
    output logic                   iter_valid_o,
    output logic                   scalar_only_o,
    output logic                   region_open_o
);
    typedef struct packed {
        logic             open;
        logic [PC_W-1:0]  head;
        logic             counted;
        logic [ITERS-1:0] done;
        logic             flush;
        logic [PC_W-1:0]  rpc;
        logic [IT_W-1:0]  riter;
        logic             iv;
        logic             so;
    } state_t;

    state_t st_d, st_q;

    logic [IT_W-1:0] cmpl_iter [NUM_FU];
    for (genvar g = 0; g < NUM_FU; g++) begin : g_unpack
        assign cmpl_iter[g] = cmpl_iter_i[g*IT_W +: IT_W];
    end

    logic [IT_W-1:0] oldest_idx;
    logic            oldest_found;
    logic            exc_any;
    logic [PC_W-1:0] exc_pc;

    rrx_oldest_enc #(.N(ITERS), .W(IT_W)) u_enc (
        .done_i  (st_q.done),
        .idx_o   (oldest_idx),
        .found_o (oldest_found)
    );

    rrx_fault_pick #(.N(NUM_FU), .PC_W(PC_W)) u_pick (
        .vld_i (exc_vld_i),
        .pcs_i (exc_pc_i),
        .any_o (exc_any),
        .pc_o  (exc_pc)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.flush) begin
            if (flush_ack_i) st_d.flush = 1'b0;
        end else if (exc_any) begin
            st_d.flush = 1'b1;
            if (st_q.open) begin
                st_d.rpc   = st_q.head;
                st_d.so    = 1'b1;
                st_d.iv    = st_q.counted & oldest_found;
                st_d.riter = (st_q.counted & oldest_found) ? oldest_idx : '0;
            end else begin
                st_d.rpc   = exc_pc;
                st_d.so    = 1'b0;
                st_d.iv    = 1'b0;
                st_d.riter = '0;
            end
        end else if (mark_begin_i) begin
            st_d.open    = 1'b1;
            st_d.head    = mark_pc_i;
            st_d.counted = counted_i;
            st_d.done    = '0;
        end else if (mark_end_i) begin
            st_d.open    = 1'b0;
            st_d.counted = 1'b0;
            st_d.done    = '0;
        end else if (st_q.open && st_q.counted) begin
            for (int f = 0; f < NUM_FU; f++) begin
                if (cmpl_vld_i[f]) st_d.done[cmpl_iter[f]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flush_o        = st_q.flush;
    assign restart_pc_o   = st_q.rpc;
    assign restart_iter_o = st_q.riter;
    assign iter_valid_o   = st_q.iv;
    assign scalar_only_o  = st_q.so;
    assign region_open_o  = st_q.open;

    assert_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mark_begin_i && !(|exc_vld_i) && !flush_o |=> region_open_o);

    assert_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_o) |-> $past(|exc_vld_i));

    assert_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_o) |-> (scalar_only_o == $past(region_open_o)));

    assert_noiter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_o) && !scalar_only_o |-> !iter_valid_o);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o && !flush_ack_i |=> flush_o && $stable(restart_pc_o)
            && $stable(restart_iter_o) && $stable(scalar_only_o));

    assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o && flush_ack_i |=> !flush_o);
endmodule

// File: tb/tb_rrx_ctrl.sv
module tb_rrx_ctrl;
    localparam int PC_W = 32, NF = 3, ITERS = 8, IT_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mb = 0, me = 0, cnt = 0, ack = 0;
    logic [PC_W-1:0] mpc = '0;
    logic [NF-1:0] cv = '0, ev = '0;
    logic [NF*IT_W-1:0] ci = '0;
    logic [NF*PC_W-1:0] epc = '0;
    logic flush_o, iv_o, so_o, open_o;
    logic [PC_W-1:0] rpc_o;
    logic [IT_W-1:0] rit_o;

    always #10 clk = ~clk;

    rrx_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mark_begin_i(mb), .mark_end_i(me),
        .mark_pc_i(mpc), .counted_i(cnt), .cmpl_vld_i(cv), .cmpl_iter_i(ci),
        .exc_vld_i(ev), .exc_pc_i(epc), .flush_ack_i(ack),
        .flush_o(flush_o), .restart_pc_o(rpc_o), .restart_iter_o(rit_o),
        .iter_valid_o(iv_o), .scalar_only_o(so_o), .region_open_o(open_o)
    );

    int n_cmp = 0, n_bad = 0;
    bit done_run = 0;

    // behavioural reference
    bit m_open, m_cnt, m_fl, m_iv, m_so;
    int m_head, m_pc, m_it;
    bit m_done [ITERS];

    task automatic model_reset();
        m_open = 0; m_cnt = 0; m_fl = 0; m_iv = 0; m_so = 0;
        m_head = 0; m_pc = 0; m_it = 0;
        foreach (m_done[i]) m_done[i] = 0;
    endtask

    task automatic model_step();
        if (m_fl) begin
            if (ack) m_fl = 0;
        end else if (ev != 0) begin
            m_fl = 1;
            if (m_open) begin
                m_pc = m_head; m_so = 1; m_iv = 0; m_it = 0;
                if (m_cnt) begin
                    for (int i = ITERS - 1; i >= 0; i--)
                        if (!m_done[i]) begin m_it = i; m_iv = 1; end
                end
            end else begin
                m_so = 0; m_iv = 0; m_it = 0;
                for (int f = NF - 1; f >= 0; f--)
                    if (ev[f]) m_pc = int'(epc[f*PC_W +: PC_W]);
            end
        end else if (mb) begin
            m_open = 1; m_head = int'(mpc); m_cnt = cnt;
            foreach (m_done[i]) m_done[i] = 0;
        end else if (me) begin
            m_open = 0; m_cnt = 0;
            foreach (m_done[i]) m_done[i] = 0;
        end else if (m_open && m_cnt) begin
            for (int f = 0; f < NF; f++)
                if (cv[f]) m_done[ci[f*IT_W +: IT_W]] = 1;
        end
    endtask

    task automatic compare(string tag);
        n_cmp++;
        if (flush_o !== m_fl || rpc_o !== PC_W'(m_pc) || rit_o !== IT_W'(m_it) ||
            iv_o !== m_iv || so_o !== m_so || open_o !== m_open) begin
            n_bad++;
            $display("FAIL %s: got fl=%0d pc=%h it=%0d iv=%0d so=%0d open=%0d exp fl=%0d pc=%h it=%0d iv=%0d so=%0d open=%0d",
                tag, flush_o, rpc_o, rit_o, iv_o, so_o, open_o,
                m_fl, m_pc, m_it, m_iv, m_so, m_open);
        end
    endtask

    // inputs already driven; advance one clock and compare
    task automatic cyc(string tag);
        model_step();
        @(posedge clk); #1;
        compare(tag);
        @(negedge clk);
        mb = 0; me = 0; cnt = 0; ack = 0; cv = '0; ev = '0; ci = '0; epc = '0; mpc = '0;
    endtask

    task automatic cmpl(int f, int it);
        cv[f] = 1; ci[f*IT_W +: IT_W] = IT_W'(it);
    endtask

    task automatic exc(int f, int pc);
        ev[f] = 1; epc[f*PC_W +: PC_W] = PC_W'(pc);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1 compare("R1");
        cyc("R1");

        // plain region, out-of-order completions, fault in region
        mb = 1; mpc = 32'h1000; cyc("R2");
        cmpl(2, 1); cmpl(0, 4); cyc("R2");
        exc(1, 32'h1044); cyc("R3 R6");
        exc(0, 32'h9); mb = 1; mpc = 32'h7; cyc("R11");
        cmpl(1, 0); cyc("R11");
        ack = 1; cyc("R11");
        cyc("R11");

        // close, then simultaneous faults outside region
        me = 1; cyc("R10");
        exc(2, 32'h2222); exc(0, 32'h1111); cyc("R4 R7");
        cyc("R7");
        ack = 1; cyc("R11");

        // counted loop
        mb = 1; cnt = 1; mpc = 32'h2000; cyc("R2");
        cmpl(1, 3); cyc("R5");
        cmpl(0, 0); cmpl(2, 1); cyc("R5");
        exc(2, 32'h2010); cmpl(0, 2); cyc("R5 R8");
        ack = 1; cyc("R11");
        for (int i = 2; i < ITERS; i++) begin cmpl(i % NF, i); cyc("R5"); end
        exc(0, 32'h2020); cyc("R5");
        ack = 1; cyc("R11");

        // restacked begin
        mb = 1; cnt = 1; mpc = 32'h3000; cyc("R2");
        cmpl(0, 0); cmpl(1, 1); cyc("R5");
        mb = 1; cnt = 1; mpc = 32'h4000; cyc("R9");
        cmpl(2, 1); cyc("R9");
        exc(1, 32'h4008); cyc("R9");
        ack = 1; cyc("R11");

        // marker collides with exception
        mb = 1; mpc = 32'h5000; exc(0, 32'h4010); cyc("R12");
        ack = 1; cyc("R12");
        mb = 1; me = 1; mpc = 32'h6000; cyc("R12");
        exc(2, 32'h6004); cyc("R12 R3");
        ack = 1; cyc("R11");
        me = 1; cyc("R10");
        exc(1, 32'hABC0); cyc("R10 R4");
        ack = 1; cyc("R11");
        cyc("R1");
        done_run = 1;
    end

    initial begin
        fork
            wait (done_run);
            begin
                repeat (5000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog: got timeout exp completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule